// File: doc/BRIEF.md
# Adaptive Frequency-Tracking Quadrature Oscillator

This core follows a single pure sinusoid that arrives as signed sample words. It runs a quadrature oscillator of its own and compares the input with the oscillator's in-phase state. The resulting error drives both oscillator states, and through an adaptation gain it also drives the oscillator's angular frequency. The loop therefore steers its own pole pair onto the input tone without a separate phase detector or loop filter.

Every state advances once per accepted sample by trapezoidal integration. The derivatives are always formed from the states held after the previous sample, so that one-sample delay breaks the algebraic loop of the closed update. All variables are 40-bit words in two fixed-point formats:
- fine: 4 integer and 36 fraction bits, for the states, the error and the half sample period;
- coarse: 24 integer and 16 fraction bits, for the derivatives, the frequency and the gains.

Each result is truncated back to its destination format. A lock flag reports when the per-sample frequency step has stayed small for a fixed run of samples.

Samples enter on a valid/ready stream and each accepted sample produces one result beat on a valid/ready output stream. The output register holds the result until it is taken. While a result waits with `out_ready` low, `in_ready` is low and no new sample is taken. A result may be drained and a new sample taken in the same cycle. The half sample period, both gains and the lock threshold are plain inputs. Suggested settings for a 4 MHz sample rate, which is 20 times the 200 kHz ceiling, are these raw words:
- `half_ts` = 8590
- `gain_k` = 655360 (10)
- `gain_w` = 6553600 (100)

Top module: `fpll_core`

## Requirements
- R1: After reset `out_i` and `out_q` hold 1.0 in the fine format (raw 2^36), `out_freq` holds 2π rad/s in the coarse format (raw 411775), `lock` and `out_valid` are 0, and `in_ready` is 1.
- R2: The input sample is read as a signed fraction with IN_W-1 fraction bits and is shifted left into the fine format. The error equals that value minus the in-phase state from before the sample.
- R3: With derivatives d_i = K·e − ω·q and d_q = ω·i, each oscillator state becomes state + (half_ts·(d[n] + d[n−1])) >> 16, truncated to 40 bits with wrap. Each product of two 40-bit words is formed at full width and arithmetic-shifted right by 36. The previous derivative is 0 after reset.
- R4: The frequency becomes ω + (half_ts·(d_w[n] + d_w[n−1])) >> 36, where d_w = Gw·(e·q), and the result saturates to the signed 40-bit range instead of wrapping.
- R5: A sample is accepted on a cycle with `in_valid` and `in_ready` both high. The next cycle shows `out_valid` high and the updated outputs. With no acceptance, `out_valid` falls after a cycle with `out_ready` high.
- R6: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` low, all outputs stay unchanged.
- R7: A sample counts as quiet when |ω_new − ω_old| < `lock_thr` (raw, unsigned). `lock` rises in the cycle after the LOCK_LEN-th consecutive quiet accepted sample (256 by default) and not before.
- R8: `lock` falls after the first accepted sample that is not quiet. With `lock_thr` = 0, `lock` never rises.
- R9: Cycles without an accepted sample leave the states, the frequency and `lock` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Core can take a sample |
| in_sample | input | IN_W | Signed input sample |
| half_ts | input | 40 | Half the sample period, fine format |
| gain_k | input | 40 | Loop gain K, coarse format |
| gain_w | input | 40 | Frequency adaptation gain Gw, coarse format |
| lock_thr | input | 40 | Lock threshold on the frequency step, coarse raw |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| out_i | output | 40 | In-phase state, fine format |
| out_q | output | 40 | Quadrature state, fine format |
| out_freq | output | 40 | Angular frequency estimate, coarse format |
| lock | output | 1 | Frequency settled |

## Verification
The bench checks every result bit-exactly against the update equations while tones, gapped valid patterns and stalled outputs are applied. An error that used the freshly updated in-phase state, or a dropped previous-derivative term, shows up within the first few samples. A product rescaled by the wrong shift would show up the same way. One scenario drives the frequency past its negative limit in two samples: a design that wraps there reports a large positive frequency instead of the minimum word. The lock run checks the exact sample on which the flag rises, then that a single large step clears it, and finally that a zero threshold keeps it low. An off-by-one counter or a `<=` comparison fails one of these three checks. Stalls with new samples pending catch a design that accepts input or updates its outputs while its result has not been taken.

// File: rtl/fpll_pkg.sv
package fpll_pkg;
  localparam int DATA_W      = 40;
  localparam int FRAC_FINE   = 36;
  localparam int FRAC_COARSE = 16;
  localparam int PROD_W      = 2 * DATA_W + 2;
  localparam int NUM_STATES  = 3;
  localparam int IDX_I       = 0;
  localparam int IDX_Q       = 1;
  localparam int IDX_W       = 2;

  typedef logic signed [DATA_W-1:0] word_t;

  localparam word_t ONE_FINE   = {{(DATA_W-FRAC_FINE-1){1'b0}}, 1'b1, {FRAC_FINE{1'b0}}};
  localparam word_t OMEGA_INIT = word_t'(411775);
  localparam word_t WORD_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
  localparam word_t WORD_MIN   = {1'b1, {(DATA_W-1){1'b0}}};

  // Full-width signed product, rescaled by the fine fraction width and truncated.
  function automatic word_t mul_q(word_t a, word_t b);
    logic [2*DATA_W-1:0]        p;
    logic signed [2*DATA_W-1:0] s;
    p = {{DATA_W{a[DATA_W-1]}}, a} * {{DATA_W{b[DATA_W-1]}}, b};
    s = $signed(p) >>> FRAC_FINE;
    return s[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/fpll_rates.sv
module fpll_rates
  import fpll_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0] sample,
  input  word_t           st_i,
  input  word_t           st_q,
  input  word_t           omega,
  input  word_t           gk,
  input  word_t           gw,
  output word_t           d_i,
  output word_t           d_q,
  output word_t           d_w
);
  localparam int ALIGN = FRAC_FINE - (IN_W - 1);

  word_t u_fine;
  word_t err;
  word_t err_q;

  assign u_fine = {{(DATA_W-IN_W){sample[IN_W-1]}}, sample} << ALIGN;
  assign err    = u_fine - st_i;
  assign err_q  = mul_q(err, st_q);

  assign d_i = mul_q(gk, err) - mul_q(omega, st_q);
  assign d_q = mul_q(omega, st_i);
  assign d_w = mul_q(gw, err_q);
endmodule

// File: rtl/fpll_trap_step.sv
module fpll_trap_step
  import fpll_pkg::*;
#(
  parameter int SHIFT = FRAC_COARSE,
  parameter bit SAT   = 1'b0
) (
  input  word_t half_ts,
  input  word_t deriv,
  input  word_t deriv_prev,
  input  word_t state,
  output word_t state_nxt
);
  logic [DATA_W:0]          dsum;
  logic [PROD_W-1:0]        prod;
  logic signed [PROD_W-1:0] incr;
  logic [PROD_W-1:0]        total;

  assign dsum  = {deriv[DATA_W-1], deriv} + {deriv_prev[DATA_W-1], deriv_prev};
  assign prod  = {{(DATA_W+2){half_ts[DATA_W-1]}}, half_ts} *
                 {{(DATA_W+1){dsum[DATA_W]}}, dsum};
  assign incr  = $signed(prod) >>> SHIFT;
  assign total = {{(PROD_W-DATA_W){state[DATA_W-1]}}, state} + incr;

  generate
    if (SAT) begin : g_clamp
      logic fits;
      assign fits = (&total[PROD_W-1:DATA_W-1]) | ~(|total[PROD_W-1:DATA_W-1]);
      assign state_nxt = fits ? total[DATA_W-1:0]
                              : (total[PROD_W-1] ? WORD_MIN : WORD_MAX);
    end else begin : g_wrap
      assign state_nxt = total[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fpll_lock_det.sv
module fpll_lock_det
  import fpll_pkg::*;
#(
  parameter int LOCK_LEN = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  word_t                w_now,
  input  word_t                w_nxt,
  input  logic [DATA_W-1:0]    thr,
  output logic                 lock
);
  localparam int CW = $clog2(LOCK_LEN + 1);

  logic [DATA_W:0] delta;
  logic [DATA_W:0] mag;
  logic            quiet;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cnt_nxt;

  assign delta = {w_nxt[DATA_W-1], w_nxt} - {w_now[DATA_W-1], w_now};
  assign mag   = delta[DATA_W] ? ('0 - delta) : delta;
  assign quiet = mag < {1'b0, thr};

  always_comb begin
    if (!quiet)                      cnt_nxt = '0;
    else if (cnt == CW'(LOCK_LEN))   cnt_nxt = cnt;
    else                             cnt_nxt = cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      lock <= 1'b0;
    end else if (step) begin
      cnt  <= cnt_nxt;
      lock <= quiet && (cnt_nxt == CW'(LOCK_LEN));
    end
  end
endmodule

// File: rtl/fpll_core.sv
module fpll_core
  import fpll_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int LOCK_LEN = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [IN_W-1:0]         in_sample,
  input  logic [DATA_W-1:0]       half_ts,
  input  logic [DATA_W-1:0]       gain_k,
  input  logic [DATA_W-1:0]       gain_w,
  input  logic [DATA_W-1:0]       lock_thr,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [DATA_W-1:0]       out_i,
  output logic [DATA_W-1:0]       out_q,
  output logic [DATA_W-1:0]       out_freq,
  output logic                    lock
);
  logic  accept;
  word_t st    [NUM_STATES];
  word_t st_nx [NUM_STATES];
  word_t der   [NUM_STATES];
  word_t der_p [NUM_STATES];

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fpll_rates #(.IN_W(IN_W)) u_rates (
    .sample (in_sample),
    .st_i   (st[IDX_I]),
    .st_q   (st[IDX_Q]),
    .omega  (st[IDX_W]),
    .gk     (gain_k),
    .gw     (gain_w),
    .d_i    (der[IDX_I]),
    .d_q    (der[IDX_Q]),
    .d_w    (der[IDX_W])
  );

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_state
    localparam bit    IS_W  = (g == IDX_W);
    localparam int    SH    = IS_W ? FRAC_FINE : FRAC_COARSE;
    localparam word_t INIT  = IS_W ? OMEGA_INIT : ONE_FINE;

    fpll_trap_step #(.SHIFT(SH), .SAT(IS_W)) u_step (
      .half_ts    (half_ts),
      .deriv      (der[g]),
      .deriv_prev (der_p[g]),
      .state      (st[g]),
      .state_nxt  (st_nx[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[g]    <= INIT;
        der_p[g] <= '0;
      end else if (accept) begin
        st[g]    <= st_nx[g];
        der_p[g] <= der[g];
      end
    end
  end

  fpll_lock_det #(.LOCK_LEN(LOCK_LEN)) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (accept),
    .w_now (st[IDX_W]),
    .w_nxt (st_nx[IDX_W]),
    .thr   (lock_thr),
    .lock  (lock)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     out_valid <= 1'b0;
    else if (accept)                out_valid <= 1'b1;
    else if (out_valid && out_ready) out_valid <= 1'b0;
  end

  assign out_i    = st[IDX_I];
  assign out_q    = st[IDX_Q];
  assign out_freq = st[IDX_W];
endmodule

// File: rtl/fpll_core_chk.sv
module fpll_core_chk
  import fpll_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic [DATA_W-1:0] out_freq,
  input logic              lock
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q) && $stable(out_freq));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R5
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R5
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_freq) && $stable(out_i) && $stable(out_q) && $stable(lock));
endmodule

bind fpll_core fpll_core_chk u_chk (.*);

// File: tb/fpll_core_bench.sv
module fpll_core_bench;
  localparam int LOCKN = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic in_ready;
  logic signed [15:0] in_sample;
  logic signed [39:0] half_ts, gain_k, gain_w;
  logic [39:0] lock_thr;
  logic out_valid, out_ready;
  logic [39:0] out_i, out_q, out_freq;
  logic lock;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  logic signed [39:0] m_i, m_q, m_w, m_pi, m_pq, m_pw;
  int   m_cnt;
  logic m_lock, m_ov;

  always #10 clk = ~clk;

  fpll_core u_fpll_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .half_ts(half_ts), .gain_k(gain_k), .gain_w(gain_w),
    .lock_thr(lock_thr), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .out_freq(out_freq), .lock(lock)
  );

  task automatic check(input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic signed [39:0] mq(input logic signed [39:0] a,
                                            input logic signed [39:0] b);
    logic signed [81:0] p;
    p = 82'(a) * 82'(b);
    p = p >>> 36;
    return p[39:0];
  endfunction

  function automatic logic signed [81:0] tinc(input logic signed [39:0] d,
                                              input logic signed [39:0] dp,
                                              input int sh);
    logic signed [81:0] s, p;
    s = 82'(d) + 82'(dp);
    p = 82'(half_ts) * s;
    return p >>> sh;
  endfunction

  // Reference update from R2, R3, R4, R7, R8
  task automatic model_step(input logic signed [15:0] smp);
    logic signed [39:0] u, e, di, dq, dw, ni, nq, nw;
    logic signed [81:0] tot, dlt;
    u   = 40'(smp) <<< 21;
    e   = u - m_i;
    di  = mq(gain_k, e) - mq(m_w, m_q);
    dq  = mq(m_w, m_i);
    dw  = mq(gain_w, mq(e, m_q));
    tot = tinc(di, m_pi, 16);
    ni  = m_i + tot[39:0];
    tot = tinc(dq, m_pq, 16);
    nq  = m_q + tot[39:0];
    tot = 82'(m_w) + tinc(dw, m_pw, 36);
    if (tot > 82'(40'sh7FFFFFFFFF))      nw = 40'sh7FFFFFFFFF;
    else if (tot < 82'(40'sh8000000000)) nw = 40'sh8000000000;
    else                                 nw = tot[39:0];
    dlt = 82'(nw) - 82'(m_w);
    if (dlt < 0) dlt = -dlt;
    if (dlt < 82'({1'b0, lock_thr})) begin
      if (m_cnt < LOCKN) m_cnt++;
      m_lock = (m_cnt == LOCKN);
    end else begin
      m_cnt  = 0;
      m_lock = 1'b0;
    end
    m_i = ni; m_q = nq; m_w = nw;
    m_pi = di; m_pq = dq; m_pw = dw;
  endtask

  task automatic cycle(input logic v, input logic signed [15:0] s,
                       input logic rdy, input string tag);
    logic acc, exp_rdy;
    @(negedge clk);
    in_valid = v; in_sample = s; out_ready = rdy;
    #1;
    exp_rdy = !m_ov || rdy;
    check("R6", "in_ready", 40'(in_ready), 40'(exp_rdy));
    acc = v && in_ready;
    @(posedge clk);
    #1;
    if (acc) begin
      model_step(s);
      m_ov = 1'b1;
    end else if (m_ov && rdy) begin
      m_ov = 1'b0;
    end
    check(tag, "out_valid", 40'(out_valid), 40'(m_ov));
    check(tag, "out_i", out_i, m_i);
    check(tag, "out_q", out_q, m_q);
    check(tag, "out_freq", out_freq, m_w);
    check(tag, "lock", 40'(lock), 40'(m_lock));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_sample = '0;
    m_i = 40'sh1000000000; m_q = 40'sh1000000000; m_w = 40'sd411775;
    m_pi = '0; m_pq = '0; m_pw = '0; m_cnt = 0; m_lock = 1'b0; m_ov = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_defaults();
    half_ts = 40'sd8590; gain_k = 40'sd655360; gain_w = 40'sd6553600;
    lock_thr = 40'h0000FFFFFF;
  endtask

  task automatic t_reset();
    set_defaults();
    do_reset();
    #1;
    check("R1", "out_i", out_i, 40'h1000000000);
    check("R1", "out_q", out_q, 40'h1000000000);
    check("R1", "out_freq", out_freq, 40'd411775);
    check("R1", "lock", 40'(lock), 40'd0);
    check("R1", "out_valid", 40'(out_valid), 40'd0);
    check("R1", "in_ready", 40'(in_ready), 40'd1);
  endtask

  task automatic t_tone(input int period, input real amp, input int n, input int gap_mod);
    for (int k = 0; k < n; k++) begin
      logic signed [15:0] s;
      logic v, r;
      s = 16'(int'(amp * 32767.0 * $sin(2.0 * 3.14159265358979 * k / period)));
      v = (k % 7) != 3;                 // gaps exercise R9
      r = (gap_mod == 0) ? 1'b1 : ((k % gap_mod) != 0);
      cycle(v, s, r, "R3");
    end
  endtask

  task automatic t_backpressure();
    logic [39:0] hold_f;
    cycle(1'b1, 16'sd1200, 1'b0, "R5");
    hold_f = out_freq;
    for (int k = 0; k < 3; k++) cycle(1'b1, 16'sd9000, 1'b0, "R6");
    check("R6", "freq held under stall", out_freq, hold_f);
    cycle(1'b0, 16'sd0, 1'b1, "R5");
    check("R5", "drained out_valid", 40'(out_valid), 40'd0);
    cycle(1'b1, -16'sd700, 1'b1, "R5");
    cycle(1'b1, 16'sd300, 1'b1, "R5");
  endtask

  task automatic t_lock();
    set_defaults();
    gain_k = '0; gain_w = '0; lock_thr = 40'd1;
    do_reset();
    for (int k = 0; k < LOCKN - 1; k++) cycle(1'b1, 16'sd0, 1'b1, "R7");
    check("R7", "lock before run complete", 40'(lock), 40'd0);
    cycle(1'b1, 16'sd0, 1'b1, "R7");
    check("R7", "lock after full run", 40'(lock), 40'd1);
    cycle(1'b0, 16'sd0, 1'b1, "R9");
    check("R9", "lock held while idle", 40'(lock), 40'd1);
    gain_w = 40'sh1000000000;
    cycle(1'b1, 16'sd16384, 1'b1, "R8");
    check("R8", "lock after large step", 40'(lock), 40'd0);
  endtask

  task automatic t_zero_thr();
    set_defaults();
    gain_w = '0; lock_thr = '0;
    do_reset();
    for (int k = 0; k < LOCKN + 40; k++) cycle(1'b1, 16'sd500, 1'b1, "R8");
    check("R8", "lock with zero threshold", 40'(lock), 40'd0);
  endtask

  task automatic t_saturate();
    half_ts = 40'sh1000000000; gain_k = '0; gain_w = 40'sh2000000000;
    lock_thr = 40'd1;
    do_reset();
    cycle(1'b1, -16'sd32768, 1'b1, "R4");
    check("R2", "first-sample freq", out_freq, 40'sd411775 - 40'sh4000000000);
    cycle(1'b1, -16'sd32768, 1'b1, "R4");
    check("R4", "saturated freq", out_freq, 40'h8000000000);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_sample = '0;
    set_defaults();
    t_reset();
    t_tone(80, 0.5, 400, 0);
    t_backpressure();
    t_tone(200, 0.9, 300, 5);
    t_lock();
    t_zero_thr();
    t_saturate();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog: actual 200000 cycles expected completion sooner");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule